// File: doc/BRIEF.md
# Non-Restoring Binary Divider

This block divides an unsigned dividend by a narrower unsigned divisor using radix-2 non-restoring division. By default the dividend is 8 bits wide and the divisor is 4 bits wide. The quotient is as wide as the dividend minus the divisor width, and the remainder is as wide as the divisor.

Each iteration doubles the signed partial remainder and brings in the next dividend bit. It then subtracts the divisor if the previous partial remainder was non-negative, or adds it if that remainder was negative. The operation taken is recorded as a signed quotient digit of +1 or −1. After the last iteration, a single fix-up stage converts the signed-digit word to binary. If the final partial remainder is negative, that stage adds the divisor back once and lowers the quotient by one.

A pulse on `start` while the block is idle launches a division. A zero divisor, or a dividend whose upper bits already reach the divisor, is answered at once with a flag and no iterations. All outputs are registered. They hold their values until the next accepted start.

Top module: `nrdiv_core`

## Requirements
- R1: For a non-zero divisor D and a dividend X whose upper 4 bits are below D, the results are quotient = floor(X/D) and remainder = X mod D, with both flags low.
- R2: For such a division, `busy` is high from the edge that accepts `start` until `done` rises. `done` rises 5 clock edges after the accepting edge, which is one edge per quotient bit plus one fix-up edge.
- R3: A zero divisor sets `div_by_zero` to 1, `overflow` to 0, the quotient to all ones and the remainder to 0. `done` is raised on the accepting edge itself, and `busy` stays low.
- R4: A non-zero divisor with upper 4 dividend bits greater than or equal to D sets `overflow` to 1, `div_by_zero` to 0, the quotient to all ones and the remainder to 0. `done` is raised on the accepting edge, and `busy` stays low.
- R5: A `start` pulse that arrives while `busy` is high is ignored. The result delivered matches the operands that were accepted first.
- R6: `done` is high for exactly one cycle. The quotient, remainder and flags hold their values until the next accepted `start`.
- R7: After reset, `busy`, `done`, both flags, the quotient and the remainder are all 0.
- R8: On any non-exceptional division, the remainder is strictly less than the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request, taken only while idle |
| dividend | input | 8 | Unsigned dividend |
| divisor | input | 4 | Unsigned divisor |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle result strobe |
| quotient | output | 4 | Binary quotient |
| remainder | output | 4 | Non-negative remainder |
| div_by_zero | output | 1 | Divisor was zero |
| overflow | output | 1 | Quotient would not fit its width |

## Verification
The hardest case to reach is the closing correction. In that case the final partial remainder is negative, so both the add-back and the quotient decrement must act together. Only particular pairings of dividend and divisor produce it, so the bench runs all 4096 operand pairs. This sweep covers every corrected and uncorrected ending, as well as both early-exit cases. In a separate run, a second `start` with different operands is injected in the middle of the iterations, to show that the accepted operands are left untouched.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } nrd_state_e;
endpackage

// File: rtl/nrd_screen.sv
// Up-front screening: zero divisor and quotient-width overflow.
module nrd_screen #(
  parameter int DIVIDEND_W = 8,
  parameter int DIVISOR_W  = 4
) (
  input  logic [DIVIDEND_W-1:0] dividend,
  input  logic [DIVISOR_W-1:0]  divisor,
  output logic                  zero_div,
  output logic                  too_big
);
  localparam int QUO_W = DIVIDEND_W - DIVISOR_W;

  logic [DIVISOR_W-1:0] upper;

  always_comb begin
    upper    = dividend[DIVIDEND_W-1:QUO_W];
    zero_div = (divisor == '0);
    too_big  = !zero_div && (upper >= divisor);
  end
endmodule

// File: rtl/nrd_step.sv
// One radix-2 non-restoring iteration on a two's-complement partial remainder.
module nrd_step #(
  parameter int DIVISOR_W = 4,
  parameter int PR_W      = DIVISOR_W + 2
) (
  input  logic [PR_W-1:0]      pr,
  input  logic                 bit_in,
  input  logic [DIVISOR_W-1:0] divisor,
  output logic [PR_W-1:0]      pr_next,
  output logic                 digit_pos
);
  logic [PR_W-1:0] shifted;
  logic [PR_W-1:0] dext;

  always_comb begin
    shifted   = {pr[PR_W-2:0], bit_in};
    dext      = PR_W'(divisor);
    // sign of the previous remainder picks subtract (+1 digit) or add (-1 digit)
    digit_pos = ~pr[PR_W-1];
    pr_next   = digit_pos ? (shifted - dext) : (shifted + dext);
  end
endmodule

// File: rtl/nrd_fixup.sv
// Signed-digit to binary conversion with the final remainder correction.
module nrd_fixup #(
  parameter int QUO_W     = 4,
  parameter int DIVISOR_W = 4,
  parameter int PR_W      = DIVISOR_W + 2
) (
  input  logic [QUO_W-1:0]     digits,
  input  logic [PR_W-1:0]      pr,
  input  logic [DIVISOR_W-1:0] divisor,
  output logic [QUO_W-1:0]     quotient,
  output logic [DIVISOR_W-1:0] remainder
);
  localparam int SQ_W = QUO_W + 2;

  logic [SQ_W-1:0] q_sd;
  logic [SQ_W-1:0] q_adj;
  logic [PR_W-1:0] r_adj;
  logic            neg;

  always_comb begin
    // digit word B (1 = +1, 0 = -1) has value 2B - (2^n - 1)
    q_sd      = {1'b0, digits, 1'b0} - SQ_W'((2 ** QUO_W) - 1);
    neg       = pr[PR_W-1];
    q_adj     = neg ? (q_sd - SQ_W'(1)) : q_sd;
    r_adj     = neg ? (pr + PR_W'(divisor)) : pr;
    quotient  = q_adj[QUO_W-1:0];
    remainder = r_adj[DIVISOR_W-1:0];
  end
endmodule

// File: rtl/nrdiv_core.sv
module nrdiv_core #(
  parameter int DIVIDEND_W = 8,
  parameter int DIVISOR_W  = 4
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic [DIVIDEND_W-1:0]            dividend,
  input  logic [DIVISOR_W-1:0]             divisor,
  output logic                             busy,
  output logic                             done,
  output logic [DIVIDEND_W-DIVISOR_W-1:0]  quotient,
  output logic [DIVISOR_W-1:0]             remainder,
  output logic                             div_by_zero,
  output logic                             overflow
);
  import nrdiv_pkg::*;

  localparam int QUO_W = DIVIDEND_W - DIVISOR_W;
  localparam int PR_W  = DIVISOR_W + 2;
  localparam int CNT_W = (QUO_W > 1) ? $clog2(QUO_W) : 1;

  nrd_state_e           state;
  logic [PR_W-1:0]      pr;
  logic [QUO_W-1:0]     low_bits;
  logic [QUO_W-1:0]     digits;
  logic [CNT_W-1:0]     cnt;
  logic [DIVISOR_W-1:0] dvs_q;

  logic                 zero_div, too_big;
  logic [PR_W-1:0]      pr_next;
  logic                 digit_pos;
  logic [QUO_W-1:0]     fix_q;
  logic [DIVISOR_W-1:0] fix_r;

  nrd_screen #(.DIVIDEND_W(DIVIDEND_W), .DIVISOR_W(DIVISOR_W)) u_screen (
    .dividend (dividend),
    .divisor  (divisor),
    .zero_div (zero_div),
    .too_big  (too_big)
  );

  nrd_step #(.DIVISOR_W(DIVISOR_W), .PR_W(PR_W)) u_step (
    .pr        (pr),
    .bit_in    (low_bits[QUO_W-1]),
    .divisor   (dvs_q),
    .pr_next   (pr_next),
    .digit_pos (digit_pos)
  );

  nrd_fixup #(.QUO_W(QUO_W), .DIVISOR_W(DIVISOR_W), .PR_W(PR_W)) u_fixup (
    .digits    (digits),
    .pr        (pr),
    .divisor   (dvs_q),
    .quotient  (fix_q),
    .remainder (fix_r)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pr          <= '0;
      low_bits    <= '0;
      digits      <= '0;
      cnt         <= '0;
      dvs_q       <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
      overflow    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            dvs_q <= divisor;
            if (zero_div || too_big) begin
              div_by_zero <= zero_div;
              overflow    <= too_big;
              quotient    <= '1;
              remainder   <= '0;
              done        <= 1'b1;
            end else begin
              div_by_zero <= 1'b0;
              overflow    <= 1'b0;
              pr          <= PR_W'(dividend[DIVIDEND_W-1:QUO_W]);
              low_bits    <= dividend[QUO_W-1:0];
              digits      <= '0;
              cnt         <= '0;
              busy        <= 1'b1;
              state       <= ST_RUN;
            end
          end
        end
        ST_RUN: begin
          pr       <= pr_next;
          low_bits <= low_bits << 1;
          digits   <= {digits[QUO_W-2:0], digit_pos};
          cnt      <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(QUO_W - 1)) state <= ST_FIX;
        end
        ST_FIX: begin
          quotient  <= fix_q;
          remainder <= fix_r;
          done      <= 1'b1;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // partial remainder must stay in [-D, D) while iterating
  logic [PR_W-1:0] pr_plus_d;
  assign pr_plus_d = pr + PR_W'(dvs_q);

  a_r1_pr_range: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN) |-> (pr[PR_W-1] ? !pr_plus_d[PR_W-1] : (pr < PR_W'(dvs_q))));

  a_r2_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  a_r3_zero_div_result: assert property (@(posedge clk) disable iff (rst)
    (done && div_by_zero) |-> (quotient == '1 && !overflow && remainder == '0));

  a_r5_operands_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dvs_q));

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_rem_below_div: assert property (@(posedge clk) disable iff (rst)
    (done && !div_by_zero && !overflow) |-> (remainder < dvs_q));
endmodule

// File: tb/test_nrdiv_core.sv
`timescale 1ns/1ps
module test_nrdiv_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [7:0] dividend = '0;
  logic [3:0] divisor = '0;
  logic       busy, done, div_by_zero, overflow;
  logic [3:0] quotient, remainder;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  nrdiv_core i_nrdiv_core (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero), .overflow(overflow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Launch one division; optionally inject a second start mid-run (R5).
  task automatic run_div(input int x, input int d, input bit inject);
    int edges;
    int exp_q, exp_r;
    bit exc_z, exc_o, busy_ok;
    exc_z = (d == 0);
    exc_o = !exc_z && ((x >> 4) >= d);
    if (exc_z || exc_o) begin exp_q = 15; exp_r = 0; end
    else begin exp_q = x / d; exp_r = x % d; end
    @(negedge clk);
    dividend = 8'(x); divisor = 4'(d); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    busy_ok = 1;
    while (!done && edges < 20) begin
      if (!busy) busy_ok = 0;
      if (inject && edges == 2) begin
        dividend = 8'hF7; divisor = 4'h9; start = 1'b1;
      end else start = 1'b0;
      @(posedge clk);
      @(negedge clk);
      edges++;
    end
    start = 1'b0;
    if (exc_z) begin
      check(edges == 1, "R3 latency", edges, 1);
      check(div_by_zero && !overflow && !busy, "R3 flags", {div_by_zero, overflow, busy}, 3'b100);
      check(quotient == 4'hF && remainder == 0, "R3 result", {quotient, remainder}, 8'hF0);
    end else if (exc_o) begin
      check(edges == 1, "R4 latency", edges, 1);
      check(overflow && !div_by_zero && !busy, "R4 flags", {div_by_zero, overflow, busy}, 3'b010);
      check(quotient == 4'hF && remainder == 0, "R4 result", {quotient, remainder}, 8'hF0);
    end else begin
      check(edges == 6, "R2 latency", edges, 6);
      check(busy_ok && !busy, "R2 busy window", busy_ok, 1);
      check(!div_by_zero && !overflow, "R1 flags", {div_by_zero, overflow}, 0);
      check(quotient == 4'(exp_q), inject ? "R5 result" : "R1 quotient", quotient, exp_q);
      check(remainder == 4'(exp_r), "R1 remainder", remainder, exp_r);
      check(remainder < 4'(d), "R8 remainder bound", remainder, d);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(!busy && !done && !div_by_zero && !overflow, "R7 control reset",
          {busy, done, div_by_zero, overflow}, 0);
    check(quotient == 0 && remainder == 0, "R7 data reset", {quotient, remainder}, 0);

    // exhaustive sweep of every operand pair
    for (int d = 0; d < 16; d++)
      for (int x = 0; x < 256; x++)
        run_div(x, d, 1'b0);

    // R5: start while busy must not disturb the running division
    run_div(8'd200, 13, 1'b1);

    // R6: one-cycle done, held results
    run_div(8'd100, 7, 1'b0);
    repeat (3) begin
      @(negedge clk);
      check(!done, "R6 done pulse", done, 0);
      check(quotient == 4'd14 && remainder == 4'd2, "R6 hold", {quotient, remainder}, 8'hE2);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule